// File: doc/BRIEF.md
# Eight-Channel Edge Interrupt Flagger

This block watches eight asynchronous interrupt pins and turns selected transitions on them into sticky pending flags. Each channel has its own two-bit edge selector. The selector can ignore the pin, or react to rising edges, falling edges, or both. Every pin passes through a two-stage synchronizer. An edge is found by comparing the newest synchronized sample with the sample from the cycle before.

Pending flags stay set until software writes a zero to them. A write of one leaves a flag untouched, so a read-modify-write does not lose events that arrive in between. If a new event and a clearing write reach the same flag in the same cycle, the event wins.

A byte-wide register port gives access to the selectors and the flags:

| Address | Contents |
|---------|----------|
| 0xA4 | Selectors for channels 0–3 |
| 0xA5 | Selectors for channels 4–7 |
| 0xC0 | The eight flags |

A single request line stays high while any flag is pending.

Top module: `ext_irq_flagger`

## Requirements
- R1: After a synchronous reset, the flag register (0xC0) and both selector registers (0xA4, 0xA5) read 0x00, and `irq_req` is low.
- R2: With selector code 01, a low-to-high transition on a channel's pin sets that channel's flag bit (bit n of 0xC0). A high-to-low transition does not set it.
- R3: With selector code 10, a high-to-low transition sets the channel's flag bit. A low-to-high transition does not set it.
- R4: With selector code 11, a transition in either direction sets the channel's flag bit.
- R5: With selector code 00, no transition sets the channel's flag bit.
- R6: A flag bit, once set, stays set until a write to 0xC0 carries 0 in that bit position. Writing 1 to a flag bit leaves it unchanged.
- R7: When an accepted edge and a zero-write reach the same flag bit in the same clock cycle, the bit ends up set. A zero-write to other bits in that same cycle still clears them.
- R8: Channel n (0–3) takes its selector from bits [2n+1:2n] of 0xA4. Channel n (4–7) takes its selector from bits [2(n-4)+1:2(n-4)] of 0xA5.
- R9: `irq_req` is high exactly while at least one flag bit is set.
- R10: Reads of 0xA4, 0xA5 and 0xC0 return the register contents. Reads of any other address return 0x00. Writes to any other address change no register.
- R11: A pin transition that is held stable sets its flag on the third rising clock edge after the transition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 8 | Asynchronous interrupt pins, bit n is channel n |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| irq_req | output | 1 | High while any flag is pending |

## Verification
Some behaviours are checked by assertions on every cycle:
- no flag drops without a write to the flag address;
- an edge hit always leaves its flag set on the next cycle, even when a zero-write arrives at the same time;
- no flag rises without a change on that channel's synchronized input;
- the selector registers hold their value unless written;
- the request line stays up while no write could have cleared the flags.

Other behaviours only the bench's scenarios can show: the meaning of each selector code in both directions, which field of which selector register belongs to which channel, the three-edge latency, the read decode, and the reset values.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 8;
    localparam int NUM_CH   = 8;
    localparam int SEL_W    = 2;
    localparam int SYNC_LEN = 2;

    localparam logic [ADDR_W-1:0] ADDR_SEL_BASE = 8'hA4;
    localparam logic [ADDR_W-1:0] ADDR_FLAGS    = 8'hC0;

    typedef enum logic [SEL_W-1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_ANY  = 2'b11
    } edge_sel_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_obs_t;

    function automatic edge_obs_t observe(input logic prev, input logic cur);
        edge_obs_t o;
        o.rise = ~prev & cur;
        o.fall = prev & ~cur;
        return o;
    endfunction

    function automatic logic edge_match(input edge_sel_e sel, input edge_obs_t obs);
        logic m;
        case (sel)
            EDGE_RISE: m = obs.rise;
            EDGE_FALL: m = obs.fall;
            EDGE_ANY:  m = obs.rise | obs.fall;
            default:   m = 1'b0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/irq_sync_bank.sv
module irq_sync_bank #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[0] <= '0;
                    else     stage_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/irq_edge_detect.sv
module irq_edge_detect
    import ext_irq_pkg::*;
#(
    parameter int CH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CH-1:0]     sampled,
    input  logic [CH*SEL_W-1:0] sel_vec,
    output logic [CH-1:0]     hit
);

    logic [CH-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= sampled;
    end

    genvar c;
    generate
        for (c = 0; c < CH; c++) begin : g_ch
            edge_sel_e sel_c;
            edge_obs_t obs_c;
            always_comb begin
                sel_c  = edge_sel_e'(sel_vec[c*SEL_W +: SEL_W]);
                obs_c  = observe(prev_q[c], sampled[c]);
                hit[c] = edge_match(sel_c, obs_c);
            end
        end
    endgenerate

endmodule

// File: rtl/irq_flag_regs.sv
module irq_flag_regs
    import ext_irq_pkg::*;
#(
    parameter int CH = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic [CH-1:0]       hit,
    output logic [CH-1:0]       flags,
    output logic [CH*SEL_W-1:0] sel_vec,
    output logic [DATA_W-1:0]   bus_rdata
);

    localparam int SEL_REGS = (CH * SEL_W) / DATA_W;

    logic [DATA_W-1:0] sel_q [SEL_REGS];
    logic [CH-1:0]     flag_q;
    logic              wr_flags;
    logic [CH-1:0]     keep_mask;

    assign wr_flags  = bus_wr && (bus_addr == ADDR_FLAGS);
    assign keep_mask = wr_flags ? bus_wdata[CH-1:0] : '1;

    always_ff @(posedge clk) begin
        if (rst) flag_q <= '0;
        else     flag_q <= (flag_q & keep_mask) | hit;
    end

    genvar r;
    generate
        for (r = 0; r < SEL_REGS; r++) begin : g_sel
            localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_SEL_BASE + ADDR_W'(r);
            always_ff @(posedge clk) begin
                if (rst)                               sel_q[r] <= '0;
                else if (bus_wr && bus_addr == MY_ADDR) sel_q[r] <= bus_wdata;
            end
            assign sel_vec[r*DATA_W +: DATA_W] = sel_q[r];

            AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
                !(bus_wr && bus_addr == MY_ADDR) |=> $stable(sel_q[r])) // R8
                else $error("selector register changed without a write");
        end
    endgenerate

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_FLAGS) begin
            bus_rdata[CH-1:0] = flag_q;
        end else begin
            for (int i = 0; i < SEL_REGS; i++) begin
                if (bus_addr == ADDR_SEL_BASE + ADDR_W'(i)) bus_rdata = sel_q[i];
            end
        end
    end

    assign flags = flag_q;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        !wr_flags |=> ((flag_q & $past(flag_q)) == $past(flag_q))) // R6
        else $error("flag dropped without a write");

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (|hit) |=> ((flag_q & $past(hit)) == $past(hit))) // R7
        else $error("edge hit lost");

endmodule

// File: rtl/ext_irq_flagger.sv
module ext_irq_flagger
    import ext_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] pin_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_req
);

    logic [NUM_CH-1:0]       pin_sync;
    logic [NUM_CH-1:0]       hit;
    logic [NUM_CH-1:0]       flags;
    logic [NUM_CH*SEL_W-1:0] sel_vec;

    irq_sync_bank #(.WIDTH(NUM_CH), .STAGES(SYNC_LEN)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    irq_edge_detect #(.CH(NUM_CH)) u_edge (
        .clk     (clk),
        .rst     (rst),
        .sampled (pin_sync),
        .sel_vec (sel_vec),
        .hit     (hit)
    );

    irq_flag_regs #(.CH(NUM_CH)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .hit       (hit),
        .flags     (flags),
        .sel_vec   (sel_vec),
        .bus_rdata (bus_rdata)
    );

    assign irq_req = |flags;

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (irq_req && !(bus_wr && bus_addr == ADDR_FLAGS)) |=> irq_req) // R9
        else $error("request dropped without a flag write");

    genvar c;
    generate
        for (c = 0; c < NUM_CH; c++) begin : g_chk
            AST_RISE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
                $rose(flags[c]) |-> ($past(pin_sync[c]) != $past(pin_sync[c], 2))) // R2
                else $error("flag set without an input change");
        end
    endgenerate

endmodule

// File: tb/ext_irq_flagger_tb.sv
module ext_irq_flagger_tb_top;

    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC = 14;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] pin_in;
    logic [7:0] bus_addr;
    logic       bus_wr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       irq_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_irq_flagger dut_i (
        .clk(clk), .rst(rst), .pin_in(pin_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_req(irq_req)
    );

    // vector: {channel[2:0], sel[1:0], from_level, to_level, expect_set}
    localparam logic [7:0] VEC [NVEC] = '{
        {3'd0, 2'b01, 1'b0, 1'b1, 1'b1},  // R2 rise accepted
        {3'd1, 2'b01, 1'b1, 1'b0, 1'b0},  // R2 fall ignored
        {3'd2, 2'b10, 1'b1, 1'b0, 1'b1},  // R3 fall accepted
        {3'd3, 2'b10, 1'b0, 1'b1, 1'b0},  // R3 rise ignored
        {3'd4, 2'b11, 1'b0, 1'b1, 1'b1},  // R4 rise
        {3'd5, 2'b11, 1'b1, 1'b0, 1'b1},  // R4 fall
        {3'd6, 2'b00, 1'b0, 1'b1, 1'b0},  // R5 rise ignored
        {3'd7, 2'b00, 1'b1, 1'b0, 1'b0},  // R5 fall ignored
        {3'd7, 2'b01, 1'b0, 1'b1, 1'b1},  // R8 top channel, high register
        {3'd3, 2'b11, 1'b1, 1'b0, 1'b1},  // R8 top field, low register
        {3'd4, 2'b10, 1'b1, 1'b0, 1'b1},  // R8 bottom field, high register
        {3'd6, 2'b01, 1'b0, 1'b1, 1'b1},
        {3'd1, 2'b10, 1'b1, 1'b0, 1'b1},
        {3'd5, 2'b00, 1'b0, 1'b1, 1'b0}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [7:0]  r;
        logic [15:0] selw;
        rst = 1'b1; pin_in = '0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
        wait_cycles(4);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset values
        rd(8'hC0, r); check("R1 flags", r, 8'h00);
        rd(8'hA4, r); check("R1 sel lo", r, 8'h00);
        rd(8'hA5, r); check("R1 sel hi", r, 8'h00);
        check("R1 irq", {7'd0, irq_req}, 8'h00);

        // table walk
        for (int v = 0; v < NVEC; v++) begin
            logic [2:0] ch;
            logic [1:0] sel;
            logic       l0, l1, ex;
            {ch, sel, l0, l1, ex} = VEC[v];
            wr(8'hA4, 8'h00); wr(8'hA5, 8'h00);
            pin_in = '0; pin_in[ch] = l0;
            wait_cycles(4);
            wr(8'hC0, 8'h00);
            selw = 16'(sel) << (2 * ch);
            wr(8'hA4, selw[7:0]); wr(8'hA5, selw[15:8]);
            rd(8'hA4, r); check("R10 sel lo readback", r, selw[7:0]);
            rd(8'hA5, r); check("R10 sel hi readback", r, selw[15:8]);
            pin_in[ch] = l1;
            wait_cycles(4);
            rd(8'hC0, r);
            check($sformatf("R2/R3/R4/R5/R8 vector %0d", v), r, 8'(ex) << ch);
            check("R9 irq follows flags", {7'd0, irq_req}, {7'd0, ex});
        end

        // R11 latency: rise on ch0, flag appears after third posedge
        wr(8'hA4, 8'h00); wr(8'hA5, 8'h00);
        pin_in = '0; wait_cycles(4);
        wr(8'hC0, 8'h00);
        wr(8'hA4, 8'h01);
        @(negedge clk); pin_in[0] = 1'b1;
        wait_cycles(2);
        rd(8'hC0, r); check("R11 not yet after two edges", r, 8'h00);
        wait_cycles(1);
        rd(8'hC0, r); check("R11 set after third edge", r, 8'h01);

        // R6 write-one keeps flag, then zero clears it
        wr(8'hC0, 8'hFF);
        rd(8'hC0, r); check("R6 write one keeps flag", r, 8'h01);
        wait_cycles(3);
        rd(8'hC0, r); check("R6 flag sticky", r, 8'h01);
        wr(8'hC0, 8'hFE);
        rd(8'hC0, r); check("R6 zero write clears", r, 8'h00);
        check("R9 irq low after clear", {7'd0, irq_req}, 8'h00);

        // R7 set wins: ch2 and ch3 pending, edge on ch2 collides with zero-write of both
        wr(8'hA4, 8'h00);
        pin_in = 8'h00; wait_cycles(4);
        wr(8'hC0, 8'h00);
        wr(8'hA4, 8'hF0);                 // ch2 and ch3 both-edge mode
        @(negedge clk); pin_in[3:2] = 2'b11;
        wait_cycles(4);
        rd(8'hC0, r); check("R7 setup", r, 8'h0C);
        @(negedge clk); pin_in[2] = 1'b0; // sync edge 1, then edge 2, hit at edge 3
        @(negedge clk);
        @(negedge clk);
        bus_addr = 8'hC0; bus_wdata = 8'h00; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        rd(8'hC0, r); check("R7 set beats clear", r, 8'h04);

        // R10 unmapped read/write
        wr(8'hC0, 8'h00);
        wr(8'hA4, 8'h00); wr(8'hA5, 8'h00);
        wr(8'h55, 8'hFF); wr(8'hA6, 8'hFF);
        rd(8'hA4, r); check("R10 stray write lo", r, 8'h00);
        rd(8'hA5, r); check("R10 stray write hi", r, 8'h00);
        rd(8'hA6, r); check("R10 unmapped read", r, 8'h00);

        // R1 reset clears a pending flag and selectors
        wr(8'hA5, 8'hC0);
        @(negedge clk); pin_in[7] = 1'b1;
        wait_cycles(4);
        rd(8'hC0, r); check("R4 before reset", r, 8'h80);
        rst = 1'b1; pin_in = '0;
        wait_cycles(3);
        rst = 1'b0;
        @(negedge clk);
        rd(8'hC0, r); check("R1 flags after reset", r, 8'h00);
        rd(8'hA5, r); check("R1 sel after reset", r, 8'h00);
        check("R1 irq after reset", {7'd0, irq_req}, 8'h00);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule